// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 active-low interrupt request lines and presents them to a processor as two active-high outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each source has its own configuration word. That word selects the output the source is routed to, whether the source is captured on a falling edge or sensed as an active-low level, and a 5-bit priority. A per-source mask and a controller-wide delivery gate decide which pending sources may take part in arbitration.

For each output, the block picks the best pending source and freezes its number. It then keeps the output asserted until software writes the matching release bit in the command word. After that write, a fresh arbitration may take place. Banks are chained by feeding the IRQ output of a second-level bank, inverted, into one source line of the first-level bank. A source of the second level is then released by a command write to the second-level bank, followed by one to the first-level bank. The FIQ path is active only in a bank built with `FIQ_EN` set. In every other bank, the routing bit reads as 0 and all sources go to IRQ.

Software reaches the bank through a simple word-addressed register bus. Writes take effect at the clock edge on which they are presented. Read data appears one cycle after the read strobe, together with a valid flag.

Top module: `intc_bank`

Register map (word addresses):
- 0: command, write only.
- 1: IRQ winner, read only. Bit 8 is the held flag and bits 4:0 are the source number.
- 2: FIQ winner, same layout as the IRQ winner word.
- 3: mask.
- 4: status.
- 5: global gate, bit 0.
- 32+n: configuration word of source n.

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low. The mask word (address 3) reads 0xFFFFFFFF, the status word (address 4) reads 0, the global gate (address 5) reads 1, and every configuration word reads 0.
- R2: A mask bit of 1 keeps its source out of arbitration even while that source is pending. Clearing the bit to 0 lets the source win, and the winner word then reads 0x100 plus the source number.
- R3: The configuration word of source n sits at word address 32+n and reads back what was written. Bit 0 routes the source to FIQ. Bit 1 selects the sensing, where 0 means falling-edge capture and 1 means active-low level. Bits 6:2 hold the priority.
- R4: In a bank built with `FIQ_EN` = 0, bit 0 of every configuration word is stored and read as 0. A source written with bit 0 set is delivered on `irq_o`, and `fiq_o` never rises.
- R5: For an edge-sensed source, a high-to-low transition of its line sets its status bit. The bit stays set after the line returns high.
- R6: For a level-sensed source, the status bit is 1 exactly while the line is low, one cycle behind the input.
- R7: Among pending, unmasked sources routed to the same output, the lowest priority value wins. Equal priorities go to the lowest source number.
- R8: Once an output has a winner, the output stays high and the winner number stays fixed, even when better sources arrive. This lasts until bit 0 (IRQ) of the command word is written 1. The held flag then clears, and a new arbitration follows.
- R9: Command bit 1 releases the FIQ winner in the same way. Writing only bit 0 leaves the FIQ winner and `fiq_o` unchanged.
- R10: Releasing a winner whose source is edge-sensed clears that source's status bit.
- R11: Writing the status word clears every edge-latched bit whose written value is 0 and leaves bits written as 1 unchanged.
- R12: While the global gate is 1, no new winner is captured on either output. Writing 0 to it allows delivery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| src_n | input | 32 | Active-low interrupt request lines |
| irq_o | output | 1 | Normal interrupt, high while an IRQ winner is held |
| fiq_o | output | 1 | Fast interrupt, high while an FIQ winner is held |

## Verification
The hardest situation to reach from the ports is a held winner facing a better newcomer. The newcomer must not preempt the winner, and the following release must hand the output straight to the newcomer. The stimulus holds a low-priority level source until it has won. It then pulls a better source low and unmasks it, reads the winner word unchanged, writes the release, and reads the new number. A parallel case keeps an FIQ winner alive across an IRQ release. A second instance built without FIQ routing shows the routing bit being discarded.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRI_W  = 5;
  localparam int DATA_W = 32;

  localparam int ADDR_CMD   = 0;
  localparam int ADDR_IRQID = 1;
  localparam int ADDR_FIQID = 2;
  localparam int ADDR_MASK  = 3;
  localparam int ADDR_STAT  = 4;
  localparam int ADDR_GATE  = 5;

  localparam int HELD_BIT = 8;

  // packed: pri in bits 6:2, sense in bit 1, fiq in bit 0
  typedef struct packed {
    logic [PRI_W-1:0] pri;
    logic             sense;
    logic             fiq;
  } src_cfg_t;
endpackage

// File: rtl/intc_srcdet.sv
module intc_srcdet #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_n,
  input  logic [NSRC-1:0] sense_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic smp_q;
    logic prv_q;
    logic lat_q;
    logic fall;

    assign fall = prv_q & ~smp_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q <= 1'b1;
        prv_q <= 1'b1;
        lat_q <= 1'b0;
      end else begin
        smp_q <= src_n[i];
        prv_q <= smp_q;
        if (fall && !sense_i[i])
          lat_q <= 1'b1;
        else if (clr_i[i] || sense_i[i])
          lat_q <= 1'b0;
      end
    end

    assign status_o[i] = sense_i[i] ? ~smp_q : lat_q;
  end
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter bit FIQ_EN = 1'b1,
  localparam int SRC_W  = $clog2(NSRC),
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NSRC-1:0]       status_i,
  input  logic                  irq_held_i,
  input  logic [SRC_W-1:0]      irq_id_i,
  input  logic                  fiq_held_i,
  input  logic [SRC_W-1:0]      fiq_id_i,
  output src_cfg_t [NSRC-1:0]   cfg_o,
  output logic [NSRC-1:0]       mask_o,
  output logic                  gate_o,
  output logic                  ack_irq_o,
  output logic                  ack_fiq_o,
  output logic [NSRC-1:0]       stat_clr_o
);
  logic             cfg_sel;
  logic [SRC_W-1:0] cfg_idx;
  logic             wr_cmd, wr_mask, wr_stat, wr_gate;
  logic [DATA_W-1:0] rd_mux;
  src_cfg_t          cfg_new;

  assign cfg_sel = bus_addr[ADDR_W-1];
  assign cfg_idx = bus_addr[SRC_W-1:0];

  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(ADDR_CMD));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(ADDR_MASK));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
  assign wr_gate = bus_wr && (bus_addr == ADDR_W'(ADDR_GATE));

  always_comb begin
    cfg_new     = src_cfg_t'(bus_wdata[$bits(src_cfg_t)-1:0]);
    cfg_new.fiq = cfg_new.fiq & FIQ_EN;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[i] <= '0;
      else if (bus_wr && cfg_sel && (cfg_idx == SRC_W'(i)))
        cfg_o[i] <= cfg_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
      gate_o <= 1'b1;
    end else begin
      if (wr_mask) mask_o <= bus_wdata[NSRC-1:0];
      if (wr_gate) gate_o <= bus_wdata[0];
    end
  end

  assign ack_irq_o  = wr_cmd && bus_wdata[0];
  assign ack_fiq_o  = wr_cmd && bus_wdata[1];
  assign stat_clr_o = wr_stat ? ~bus_wdata[NSRC-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (cfg_sel) begin
      rd_mux = DATA_W'(cfg_o[cfg_idx]);
    end else begin
      case (bus_addr)
        ADDR_W'(ADDR_IRQID): begin
          rd_mux           = DATA_W'(irq_id_i);
          rd_mux[HELD_BIT] = irq_held_i;
        end
        ADDR_W'(ADDR_FIQID): begin
          rd_mux           = DATA_W'(fiq_id_i);
          rd_mux[HELD_BIT] = fiq_held_i;
        end
        ADDR_W'(ADDR_MASK):  rd_mux = DATA_W'(mask_o);
        ADDR_W'(ADDR_STAT):  rd_mux = DATA_W'(status_i);
        ADDR_W'(ADDR_GATE):  rd_mux = DATA_W'(gate_o);
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRI_W-1:0]  pri_i,
  input  logic                        en_i,
  input  logic                        release_i,
  output logic                        held_o,
  output logic [SRC_W-1:0]            id_o
);
  logic             best_v;
  logic [PRI_W-1:0] best_p;
  logic [SRC_W-1:0] best_id;

  always_comb begin
    best_v  = 1'b0;
    best_p  = '1;
    best_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (!best_v || (pri_i[i] < best_p))) begin
        best_v  = 1'b1;
        best_p  = pri_i[i];
        best_id = SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_o <= 1'b0;
      id_o   <= '0;
    end else if (release_i) begin
      held_o <= 1'b0;
    end else if (!held_o && en_i && best_v) begin
      held_o <= 1'b1;
      id_o   <= best_id;
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter bit FIQ_EN = 1'b1,
  localparam int SRC_W  = $clog2(NSRC),
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   src_n,
  output logic              irq_o,
  output logic              fiq_o
);
  src_cfg_t [NSRC-1:0]       cfg;
  logic [NSRC-1:0]           mask;
  logic                      gate;
  logic                      ack_irq, ack_fiq;
  logic [NSRC-1:0]           stat_clr;
  logic [NSRC-1:0]           status;
  logic [NSRC-1:0]           sense, route_fiq;
  logic [NSRC-1:0][PRI_W-1:0] pri;
  logic [NSRC-1:0]           pending, cand_irq, cand_fiq;
  logic                      irq_held, fiq_held;
  logic [SRC_W-1:0]          irq_id, fiq_id;
  logic [NSRC-1:0]           irq_onehot, fiq_onehot, rel_clr, clr;

  for (genvar i = 0; i < NSRC; i++) begin : g_unpack
    assign sense[i]     = cfg[i].sense;
    assign route_fiq[i] = cfg[i].fiq;
    assign pri[i]       = cfg[i].pri;
  end

  intc_regfile #(.NSRC(NSRC), .FIQ_EN(FIQ_EN)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .status_i   (status),
    .irq_held_i (irq_held),
    .irq_id_i   (irq_id),
    .fiq_held_i (fiq_held),
    .fiq_id_i   (fiq_id),
    .cfg_o      (cfg),
    .mask_o     (mask),
    .gate_o     (gate),
    .ack_irq_o  (ack_irq),
    .ack_fiq_o  (ack_fiq),
    .stat_clr_o (stat_clr)
  );

  assign irq_onehot = NSRC'(1) << irq_id;
  assign fiq_onehot = NSRC'(1) << fiq_id;
  assign rel_clr    = (((ack_irq && irq_held) ? irq_onehot : '0) |
                       ((ack_fiq && fiq_held) ? fiq_onehot : '0)) & ~sense;
  assign clr        = stat_clr | rel_clr;

  intc_srcdet #(.NSRC(NSRC)) u_det (
    .clk      (clk),
    .rst      (rst),
    .src_n    (src_n),
    .sense_i  (sense),
    .clr_i    (clr),
    .status_o (status)
  );

  assign pending  = status & ~mask;
  assign cand_irq = pending & ~route_fiq;
  assign cand_fiq = pending & route_fiq;

  intc_arbiter #(.NSRC(NSRC)) u_arb_irq (
    .clk       (clk),
    .rst       (rst),
    .cand_i    (cand_irq),
    .pri_i     (pri),
    .en_i      (!gate),
    .release_i (ack_irq),
    .held_o    (irq_held),
    .id_o      (irq_id)
  );

  intc_arbiter #(.NSRC(NSRC)) u_arb_fiq (
    .clk       (clk),
    .rst       (rst),
    .cand_i    (cand_fiq),
    .pri_i     (pri),
    .en_i      (!gate),
    .release_i (ack_fiq),
    .held_o    (fiq_held),
    .id_o      (fiq_id)
  );

  assign irq_o = irq_held;
  assign fiq_o = fiq_held;
endmodule

// File: rtl/intc_bank_chk.sv
module intc_bank_chk #(
  parameter int NSRC   = 32,
  parameter bit FIQ_EN = 1'b1,
  localparam int SRC_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [SRC_W-1:0] irq_id,
  input logic [SRC_W-1:0] fiq_id,
  input logic             gate,
  input logic             ack_irq,
  input logic             ack_fiq
);
  logic rst_d;

  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_d) begin
      reset_quiet_chk: assert (!irq_o && !fiq_o);
    end
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_irq) |=> (irq_o && $stable(irq_id)));

  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_irq) |=> !irq_o);

  // R9
  fiq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fiq_o && !ack_fiq) |=> (fiq_o && $stable(fiq_id)));

  // R12
  gate_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && !irq_o) |=> !irq_o);

  // R12
  gate_fiq_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && !fiq_o) |=> !fiq_o);

  if (!FIQ_EN) begin : g_nofiq
    // R4
    fiq_absent_chk: assert property (@(posedge clk) disable iff (rst) !fiq_o);
  end
endmodule

bind intc_bank intc_bank_chk #(.NSRC(NSRC), .FIQ_EN(FIQ_EN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_o   (irq_o),
  .fiq_o   (fiq_o),
  .irq_id  (irq_id),
  .fiq_id  (fiq_id),
  .gate    (gate),
  .ack_irq (ack_irq),
  .ack_fiq (ack_fiq)
);

// File: tb/intc_bank_test.sv
`timescale 1ns/1ps
module intc_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wr    [2];
  logic        rd    [2];
  logic [5:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        rvalid[2];
  logic [31:0] src_n [2];
  logic        irq   [2];
  logic        fiq   [2];

  intc_bank #(.NSRC(32), .FIQ_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .bus_wr(wr[0]), .bus_rd(rd[0]), .bus_addr(addr[0]),
    .bus_wdata(wdata[0]), .bus_rdata(rdata[0]), .bus_rvalid(rvalid[0]),
    .src_n(src_n[0]), .irq_o(irq[0]), .fiq_o(fiq[0]));

  intc_bank #(.NSRC(32), .FIQ_EN(1'b0)) uut2 (
    .clk(clk), .rst(rst), .bus_wr(wr[1]), .bus_rd(rd[1]), .bus_addr(addr[1]),
    .bus_wdata(wdata[1]), .bus_rdata(rdata[1]), .bus_rvalid(rvalid[1]),
    .src_n(src_n[1]), .irq_o(irq[1]), .fiq_o(fiq[1]));

  localparam int A_CMD = 0, A_IRQID = 1, A_FIQID = 2, A_MASK = 3, A_STAT = 4, A_GATE = 5, A_CFG = 32;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int u, int a, logic [31:0] d);
    @(negedge clk);
    wr[u] = 1'b1; addr[u] = 6'(a); wdata[u] = d;
    @(negedge clk);
    wr[u] = 1'b0;
  endtask

  // driver: issues a read and pushes the expected value
  task automatic rd_exp(int u, int a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    rd[u] = 1'b1; addr[u] = 6'(a);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rd[u] = 1'b0;
  endtask

  task automatic set_src(int u, int i, logic v);
    @(negedge clk);
    src_n[u][i] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected item when read data is produced
  initial begin
    forever begin
      @(negedge clk);
      if (rvalid[0] || rvalid[1]) begin
        item_t it;
        if (sb.size() == 0) begin
          n_vec++; n_fail++;
          $display("FAIL scoreboard: unexpected read data");
        end else begin
          it = sb.pop_front();
          check(rvalid[0] ? rdata[0] : rdata[1], it.exp, it.tag);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      wr[u] = 0; rd[u] = 0; addr[u] = 0; wdata[u] = 0; src_n[u] = '1;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // reset state
    check(32'(irq[0]), 0, "R1 irq after reset");
    check(32'(fiq[0]), 0, "R1 fiq after reset");
    rd_exp(0, A_MASK, 32'hFFFF_FFFF, "R1 mask reset");
    rd_exp(0, A_STAT, 32'h0, "R1 status reset");
    rd_exp(0, A_GATE, 32'h1, "R1 gate reset");
    rd_exp(0, A_CFG + 5, 32'h0, "R1 cfg reset");

    // masked level source
    wr_reg(0, A_GATE, 0);
    wr_reg(0, A_CFG + 3, 32'h12);
    set_src(0, 3, 0);
    idle(4);
    check(32'(irq[0]), 0, "R2 masked source silent");
    rd_exp(0, A_STAT, 32'h8, "R6 level status while low");
    wr_reg(0, A_MASK, 32'hFFFF_FFF7);
    idle(3);
    check(32'(irq[0]), 1, "R2 unmasked source delivered");
    rd_exp(0, A_IRQID, 32'h103, "R2 winner number");
    rd_exp(0, A_CFG + 3, 32'h12, "R3 cfg readback");

    // better newcomer while held
    wr_reg(0, A_CFG + 7, 32'h06);
    set_src(0, 7, 0);
    wr_reg(0, A_MASK, 32'hFFFF_FF77);
    idle(3);
    rd_exp(0, A_IRQID, 32'h103, "R8 winner frozen");
    wr_reg(0, A_CMD, 1);
    idle(3);
    rd_exp(0, A_IRQID, 32'h107, "R7 lower priority value wins");
    set_src(0, 7, 1);
    idle(2);
    rd_exp(0, A_STAT, 32'h8, "R6 level status follows release");
    wr_reg(0, A_CMD, 1);
    idle(3);
    rd_exp(0, A_IRQID, 32'h103, "R8 re-arbitration after release");
    set_src(0, 3, 1);
    idle(2);
    wr_reg(0, A_CMD, 1);
    idle(3);
    check(32'(irq[0]), 0, "R8 irq drops after release");

    // equal priorities
    wr_reg(0, A_CFG + 10, 32'h0A);
    wr_reg(0, A_CFG + 12, 32'h0A);
    wr_reg(0, A_MASK, 32'hFFFF_EBFF);
    @(negedge clk);
    src_n[0][10] = 0; src_n[0][12] = 0;
    idle(3);
    rd_exp(0, A_IRQID, 32'h10A, "R7 tie to lowest number");
    @(negedge clk);
    src_n[0][10] = 1; src_n[0][12] = 1;
    idle(2);
    wr_reg(0, A_CMD, 1);
    idle(3);
    check(32'(irq[0]), 0, "R7 idle after tie");

    // edge source
    wr_reg(0, A_MASK, 32'hFFEF_FFFF);
    set_src(0, 20, 0);
    idle(2);
    set_src(0, 20, 1);
    idle(3);
    rd_exp(0, A_STAT, 32'h0010_0000, "R5 edge latched");
    check(32'(irq[0]), 1, "R5 edge delivered");
    rd_exp(0, A_IRQID, 32'h114, "R5 edge winner");
    wr_reg(0, A_CMD, 1);
    idle(3);
    rd_exp(0, A_STAT, 32'h0, "R10 release clears edge status");
    check(32'(irq[0]), 0, "R10 irq idle");

    // status write
    wr_reg(0, A_MASK, 32'hFFFF_FFFF);
    set_src(0, 20, 0);
    idle(2);
    set_src(0, 20, 1);
    idle(3);
    wr_reg(0, A_STAT, 32'h0010_0000);
    rd_exp(0, A_STAT, 32'h0010_0000, "R11 bit written 1 kept");
    wr_reg(0, A_STAT, 32'h0);
    rd_exp(0, A_STAT, 32'h0, "R11 bit written 0 cleared");

    // FIQ path
    wr_reg(0, A_CFG + 1, 32'h03);
    rd_exp(0, A_CFG + 1, 32'h03, "R3 fiq bit kept in first bank");
    @(negedge clk);
    src_n[0][1] = 0; src_n[0][3] = 0;
    wr_reg(0, A_MASK, 32'hFFFF_FFF5);
    idle(3);
    check(32'(fiq[0]), 1, "R9 fiq asserted");
    check(32'(irq[0]), 1, "R9 irq asserted");
    rd_exp(0, A_FIQID, 32'h101, "R9 fiq winner");
    rd_exp(0, A_IRQID, 32'h103, "R9 irq winner");
    wr_reg(0, A_CMD, 1);
    idle(3);
    check(32'(fiq[0]), 1, "R9 irq release keeps fiq");
    rd_exp(0, A_FIQID, 32'h101, "R9 fiq winner kept");
    set_src(0, 1, 1);
    idle(2);
    wr_reg(0, A_CMD, 2);
    idle(3);
    check(32'(fiq[0]), 0, "R9 fiq released");
    set_src(0, 3, 1);
    idle(2);
    wr_reg(0, A_CMD, 1);
    idle(3);

    // global gate
    wr_reg(0, A_GATE, 1);
    set_src(0, 3, 0);
    idle(4);
    check(32'(irq[0]), 0, "R12 gate blocks delivery");
    wr_reg(0, A_GATE, 0);
    idle(3);
    check(32'(irq[0]), 1, "R12 gate open delivers");
    set_src(0, 3, 1);
    idle(2);
    wr_reg(0, A_CMD, 1);
    idle(3);

    // bank without FIQ routing
    wr_reg(1, A_CFG + 1, 32'h03);
    rd_exp(1, A_CFG + 1, 32'h02, "R4 fiq bit forced to 0");
    wr_reg(1, A_GATE, 0);
    wr_reg(1, A_MASK, 32'hFFFF_FFFD);
    set_src(1, 1, 0);
    idle(3);
    check(32'(irq[1]), 1, "R4 source goes to irq");
    check(32'(fiq[1]), 0, "R4 no fiq");
    rd_exp(1, A_IRQID, 32'h101, "R4 irq winner");

    idle(3);
    if (sb.size() != 0) begin
      n_vec++; n_fail++;
      $display("FAIL scoreboard: %0d reads unanswered", sb.size());
    end
    finish_run();
  end
endmodule